// File: doc/BRIEF.md
# Four-Wire Serial Slave with Underflow and Overflow Flags

This block is the device side of a four-wire synchronous serial link. An external controller drives the serial clock, the data-in line and an active-low select. The block brings all three into its own clock domain through two-flop synchronizers and detects clock edges there. Frames of 4 to 16 bits are shifted in and out most significant bit first. Received frames go into a receive FIFO that local logic drains. Outgoing frames come from a transmit FIFO that local logic fills.

The clock polarity, the clock phase and the frame length are chosen to match the controller. A direction mode selects full duplex, send only or receive only. Two error events are kept as sticky flags, each cleared by a one-cycle write-one pulse. The first is a frame that starts while there is nothing to send. The second is a frame that completes while the receive FIFO is full. Each flag can be masked from the shared interrupt output. The serial clock must stay at or below one quarter of the local clock, because the synchronizer and edge detector need that margin.

Top module: `spi_slave_core`

## Requirements
- R1: After reset, `miso` is 1, `flag_udf`, `flag_ovf` and `irq` are 0, `rx_rvalid` is 0 and `tx_full` is 0.
- R2: The frame length is `cfg_frame_bits`, where a value below 4 acts as 4 and a value above 16 acts as 16. Both directions move the most significant bit first. A received word is right-aligned in `rx_rdata`, with the unused upper bits zero.
- R3: `cfg_cpol` gives the idle level of `sclk`. With `cfg_cpha`=0 the first outgoing bit is on `miso` once select is asserted, input is sampled on the leading edge and output changes on the trailing edge. With `cfg_cpha`=1 output changes on the leading edge and input is sampled on the trailing edge.
- R4: With `cfg_cpha`=1, several frames may follow each other while select stays low. With `cfg_cpha`=0, each frame is opened by a falling edge of `cs_n`.
- R5: When sending is enabled and the transmit FIFO is empty at the start of a frame, `flag_udf` is set and `miso` carries all ones for the whole frame.
- R6: When a frame completes while the receive FIFO is full, that frame is dropped, the words already stored are kept unchanged, and `flag_ovf` is set.
- R7: If `cs_n` rises before a frame is complete, the partial frame is discarded and the next frame starts from its first bit.
- R8: `cfg_mode` selects the direction. 2'b00 (and 2'b11) is full duplex. 2'b01 is send only: received frames are not stored and no overflow is raised. 2'b10 is receive only: `miso` is all ones, the transmit FIFO is not read, and no underflow is raised.
- R9: The flags stay set until cleared. `flag_clr[0]` clears `flag_udf` and `flag_clr[1]` clears `flag_ovf`. A new event in the same cycle as a clear wins.
- R10: `irq` is high when an unmasked flag is set. `irq_mask[0]` masks the underflow flag and `irq_mask[1]` masks the overflow flag, where a 1 masks.
- R11: `tx_full` is high once the transmit FIFO holds TX_DEPTH words, and a write while it is full is ignored. `rx_rready` with `rx_rvalid` removes the head word from the receive FIFO.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_cpol | input | 1 | Serial clock idle level |
| cfg_cpha | input | 1 | Sample phase: 0 leading edge, 1 trailing edge |
| cfg_frame_bits | input | 5 | Frame length in bits |
| cfg_mode | input | 2 | Direction mode |
| irq_mask | input | 2 | Per-flag interrupt mask, 1 masks |
| flag_clr | input | 2 | Write-one-to-clear pulses for the flags |
| tx_wdata | input | 16 | Word to send, right-aligned |
| tx_wvalid | input | 1 | Write strobe for the transmit FIFO |
| tx_full | output | 1 | Transmit FIFO full |
| rx_rdata | output | 16 | Head word of the receive FIFO |
| rx_rvalid | output | 1 | Receive FIFO not empty |
| rx_rready | input | 1 | Pop strobe for the receive FIFO |
| sclk | input | 1 | Serial clock from the controller |
| mosi | input | 1 | Serial data from the controller |
| cs_n | input | 1 | Active-low select |
| miso | output | 1 | Serial data to the controller, 1 when not selected |
| flag_udf | output | 1 | Sticky transmit-underflow flag |
| flag_ovf | output | 1 | Sticky receive-overflow flag |
| irq | output | 1 | Interrupt request |

## Verification
The frame path is driven under all four polarity and phase pairs with asymmetric words, so that bit order, sampling edge and output edge each show up as a different wrong value. Frames of 4, 8 and 16 bits, together with out-of-range length settings, separate a length fault from a clamp fault. The phase-1 back-to-back frames under one select test whether the second word loads at the first leading edge of its frame. The error cases use an empty transmit FIFO, a receive FIFO filled one frame past its depth, a select released after three bits, and both one-way modes. This tells a missing flag apart from corrupted data, a lost word, or a stale partial word.

// File: rtl/spis_pkg.sv
package spis_pkg;

  typedef enum logic [1:0] {
    MODE_DUPLEX  = 2'b00,
    MODE_TX_ONLY = 2'b01,
    MODE_RX_ONLY = 2'b10,
    MODE_RSVD    = 2'b11
  } spis_mode_e;

  localparam int FLAG_UDF = 0;
  localparam int FLAG_OVF = 1;
  localparam int NUM_FLAGS = 2;
  localparam int MIN_FRAME = 4;

  function automatic logic mode_sends(input spis_mode_e m);
    return m != MODE_RX_ONLY;
  endfunction

  function automatic logic mode_stores(input spis_mode_e m);
    return m != MODE_TX_ONLY;
  endfunction

endpackage

// File: rtl/spis_sync.sv
module spis_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= RST_VAL;
        else        chain <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= {STAGES{RST_VAL}};
        else        chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/spis_fifo.sv
module spis_fifo #(
  parameter int WIDTH = 16,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] din,
  input  logic             pop,
  output logic [WIDTH-1:0] dout,
  output logic             full,
  output logic             empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wp, rp;
  logic [AW:0]      level;
  logic             push_ok, pop_ok;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = (level == (AW+1)'(DEPTH));
  assign empty   = (level == '0);
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;
  assign dout    = mem[rp];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      level <= '0;
    end else begin
      if (push_ok) wp <= bump(wp);
      if (pop_ok)  rp <= bump(rp);
      case ({push_ok, pop_ok})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wp] <= din;
  end

  // R11: the fill level never passes the depth
  a_r11_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
    level <= (AW+1)'(DEPTH));

  // R11: a write while full leaves the level unchanged unless a read happens
  a_r11_full_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !pop) |=> full);
endmodule

// File: rtl/spis_frame.sv
module spis_frame
  import spis_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CW     = $clog2(DATA_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_s,
  input  logic              mosi_s,
  input  logic              cs_s,
  input  logic              cfg_cpol,
  input  logic              cfg_cpha,
  input  logic [CW-1:0]     cfg_bits,
  input  spis_mode_e        mode,
  input  logic              tx_empty,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              rx_full,
  output logic              tx_pop,
  output logic              rx_push,
  output logic [DATA_W-1:0] rx_word,
  output logic              udf_evt,
  output logic              ovf_evt,
  output logic              miso
);
  localparam logic [CW-1:0] MAXB = CW'(DATA_W);
  localparam logic [CW-1:0] MINB = CW'(MIN_FRAME);

  function automatic logic [CW-1:0] clamp_bits(input logic [CW-1:0] req);
    if (req < MINB) return MINB;
    if (req > MAXB) return MAXB;
    return req;
  endfunction

  function automatic logic [DATA_W-1:0] left_align(input logic [DATA_W-1:0] d,
                                                   input logic [CW-1:0] n);
    return d << (MAXB - n);
  endfunction

  function automatic logic [DATA_W-1:0] low_mask(input logic [CW-1:0] n);
    return {DATA_W{1'b1}} >> (MAXB - n);
  endfunction

  logic              sclk_d, cs_d;
  logic [CW-1:0]     cnt;
  logic [CW-1:0]     nbits;
  logic [DATA_W-1:0] tx_sh, rx_sh, rx_next;
  logic              selected, sclk_edge, lead, trail;
  logic              samp_edge, drv_edge, cs_fall;
  logic              frame_start, last_bit, sends, stores;

  assign nbits     = clamp_bits(cfg_bits);
  assign selected  = !cs_s;
  assign sclk_edge = sclk_s ^ sclk_d;
  assign lead      = selected && sclk_edge && (sclk_s != cfg_cpol);
  assign trail     = selected && sclk_edge && (sclk_s == cfg_cpol);
  assign samp_edge = cfg_cpha ? trail : lead;
  assign drv_edge  = cfg_cpha ? lead : trail;
  assign cs_fall   = cs_d && !cs_s;
  assign sends     = mode_sends(mode);
  assign stores    = mode_stores(mode);

  // Phase 0 opens a frame at select assertion; phase 1 at the first leading edge.
  assign frame_start = cfg_cpha ? (lead && (cnt == '0)) : cs_fall;
  assign tx_pop      = frame_start && sends && !tx_empty;
  assign udf_evt     = frame_start && sends && tx_empty;

  assign last_bit = samp_edge && (cnt == nbits - 1'b1);
  assign rx_next  = {rx_sh[DATA_W-2:0], mosi_s};
  assign rx_word  = rx_next & low_mask(nbits);
  assign rx_push  = last_bit && stores && !rx_full;
  assign ovf_evt  = last_bit && stores && rx_full;

  assign miso = cs_s ? 1'b1 : tx_sh[DATA_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d <= 1'b0;
      cs_d   <= 1'b1;
    end else begin
      sclk_d <= sclk_s;
      cs_d   <= cs_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      rx_sh <= '0;
    end else if (!selected) begin
      cnt <= '0;
    end else if (samp_edge) begin
      rx_sh <= rx_next;
      cnt   <= last_bit ? '0 : cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sh <= '1;
    end else if (frame_start) begin
      tx_sh <= tx_pop ? left_align(tx_data, nbits) : '1;
    end else if (drv_edge && (cnt != '0)) begin
      tx_sh <= {tx_sh[DATA_W-2:0], 1'b1};
    end
  end

  // R7: a released select leaves the bit position at the frame start
  a_r7_release_resets_count: assert property (@(posedge clk) disable iff (!rst_n)
    cs_s |=> (cnt == '0));

  // R5: an underflow loads the all-ones pattern for the frame
  a_r5_udf_loads_ones: assert property (@(posedge clk) disable iff (!rst_n)
    udf_evt |=> (tx_sh == '1));

  // R6: the receive FIFO is never written while full
  a_r6_no_store_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push |-> !rx_full);

  // R8: send-only mode never stores a word
  a_r8_tx_only_no_store: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_TX_ONLY) |-> (!rx_push && !ovf_evt));

  // R8: receive-only mode never reads the transmit FIFO
  a_r8_rx_only_no_read: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_RX_ONLY) |-> (!tx_pop && !udf_evt));
endmodule

// File: rtl/spi_slave_core.sv
module spi_slave_core
  import spis_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int TX_DEPTH = 4,
  parameter int RX_DEPTH = 4,
  parameter int SYNC_LEN = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         cfg_cpol,
  input  logic                         cfg_cpha,
  input  logic [$clog2(DATA_W+1)-1:0]  cfg_frame_bits,
  input  logic [1:0]                   cfg_mode,
  input  logic [1:0]                   irq_mask,
  input  logic [1:0]                   flag_clr,
  input  logic [DATA_W-1:0]            tx_wdata,
  input  logic                         tx_wvalid,
  output logic                         tx_full,
  output logic [DATA_W-1:0]            rx_rdata,
  output logic                         rx_rvalid,
  input  logic                         rx_rready,
  input  logic                         sclk,
  input  logic                         mosi,
  input  logic                         cs_n,
  output logic                         miso,
  output logic                         flag_udf,
  output logic                         flag_ovf,
  output logic                         irq
);
  localparam int CW = $clog2(DATA_W + 1);

  logic                 sclk_s, mosi_s, cs_s;
  logic                 tx_empty, rx_full, rx_empty;
  logic                 tx_pop, rx_push, udf_evt, ovf_evt;
  logic [DATA_W-1:0]    tx_head, rx_word;
  logic [NUM_FLAGS-1:0] flags, events;
  spis_mode_e           mode;

  assign mode = spis_mode_e'(cfg_mode);

  spis_sync #(.STAGES(SYNC_LEN), .RST_VAL(1'b0)) u_sync_sclk (
    .clk(clk), .rst_n(rst_n), .d(sclk), .q(sclk_s));
  spis_sync #(.STAGES(SYNC_LEN), .RST_VAL(1'b0)) u_sync_mosi (
    .clk(clk), .rst_n(rst_n), .d(mosi), .q(mosi_s));
  spis_sync #(.STAGES(SYNC_LEN), .RST_VAL(1'b1)) u_sync_cs (
    .clk(clk), .rst_n(rst_n), .d(cs_n), .q(cs_s));

  spis_fifo #(.WIDTH(DATA_W), .DEPTH(TX_DEPTH)) u_tx_fifo (
    .clk(clk), .rst_n(rst_n),
    .push(tx_wvalid), .din(tx_wdata),
    .pop(tx_pop), .dout(tx_head),
    .full(tx_full), .empty(tx_empty));

  spis_fifo #(.WIDTH(DATA_W), .DEPTH(RX_DEPTH)) u_rx_fifo (
    .clk(clk), .rst_n(rst_n),
    .push(rx_push), .din(rx_word),
    .pop(rx_rready), .dout(rx_rdata),
    .full(rx_full), .empty(rx_empty));

  assign rx_rvalid = !rx_empty;

  spis_frame #(.DATA_W(DATA_W), .CW(CW)) u_frame (
    .clk(clk), .rst_n(rst_n),
    .sclk_s(sclk_s), .mosi_s(mosi_s), .cs_s(cs_s),
    .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha), .cfg_bits(cfg_frame_bits),
    .mode(mode),
    .tx_empty(tx_empty), .tx_data(tx_head), .rx_full(rx_full),
    .tx_pop(tx_pop), .rx_push(rx_push), .rx_word(rx_word),
    .udf_evt(udf_evt), .ovf_evt(ovf_evt), .miso(miso));

  always_comb begin
    events = '0;
    events[FLAG_UDF] = udf_evt;
    events[FLAG_OVF] = ovf_evt;
  end

  // Sticky flags: clear first, then a same-cycle event sets again.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags <= '0;
    else        flags <= (flags & ~flag_clr) | events;
  end

  assign flag_udf = flags[FLAG_UDF];
  assign flag_ovf = flags[FLAG_OVF];
  assign irq      = |(flags & ~irq_mask);

  // R9: an uncleared underflow flag stays set
  a_r9_udf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_udf && !flag_clr[FLAG_UDF]) |=> flag_udf);

  // R9: an uncleared overflow flag stays set
  a_r9_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_ovf && !flag_clr[FLAG_OVF]) |=> flag_ovf);

  // R6: a dropped frame raises the overflow flag on the next cycle
  a_r6_ovf_raises_flag: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> flag_ovf);

  // R10: with both sources masked no request leaves the block
  a_r10_all_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (&irq_mask) |-> !irq);
endmodule

// File: tb/tb_spi_slave_core.sv
module tb_spi_slave_core;
  localparam int HALF = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_cpol = 1'b0, cfg_cpha = 1'b0;
  logic [4:0]  cfg_frame_bits = 5'd8;
  logic [1:0]  cfg_mode = 2'b00, irq_mask = 2'b00, flag_clr = 2'b00;
  logic [15:0] tx_wdata = '0;
  logic        tx_wvalid = 1'b0, rx_rready = 1'b0;
  logic        sclk = 1'b0, mosi = 1'b0, cs_n = 1'b1;
  logic        tx_full, rx_rvalid, miso, flag_udf, flag_ovf, irq;
  logic [15:0] rx_rdata;

  int          n_tests = 0, n_fail = 0;
  logic [15:0] exp_q[$];
  logic        mon_en = 1'b1;
  bit          finished = 1'b0;

  always #2.5 clk = ~clk;

  spi_slave_core dut (
    .clk(clk), .rst_n(rst_n), .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha),
    .cfg_frame_bits(cfg_frame_bits), .cfg_mode(cfg_mode), .irq_mask(irq_mask),
    .flag_clr(flag_clr), .tx_wdata(tx_wdata), .tx_wvalid(tx_wvalid),
    .tx_full(tx_full), .rx_rdata(rx_rdata), .rx_rvalid(rx_rvalid),
    .rx_rready(rx_rready), .sclk(sclk), .mosi(mosi), .cs_n(cs_n), .miso(miso),
    .flag_udf(flag_udf), .flag_ovf(flag_ovf), .irq(irq));

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  // Monitor: pops the receive FIFO and compares against the scoreboard.
  always @(negedge clk) begin
    rx_rready <= 1'b0;
    if (rst_n && mon_en && rx_rvalid && !rx_rready) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R2", "unexpected received word", {16'h0, rx_rdata}, 32'h0);
      end else begin
        logic [15:0] e;
        e = exp_q.pop_front();
        check(rx_rdata == e, "R2", "received word", {16'h0, rx_rdata}, {16'h0, e});
      end
      rx_rready <= 1'b1;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "R1", "watchdog expired", 32'h0, 32'h1);
    report();
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [15:0] fmask(input int bits);
    return 16'hFFFF >> (16 - bits);
  endfunction

  task automatic push_tx(input logic [15:0] d);
    @(negedge clk);
    tx_wdata  = d;
    tx_wvalid = 1'b1;
    @(negedge clk);
    tx_wvalid = 1'b0;
  endtask

  task automatic set_cfg(input logic pol, input logic pha, input logic [4:0] nb);
    cfg_cpol = pol;
    cfg_cpha = pha;
    cfg_frame_bits = nb;
    sclk = pol;
    tick(8);
  endtask

  task automatic cs_low();
    cs_n = 1'b0;
    tick(6);
  endtask

  task automatic cs_high();
    tick(4);
    cs_n = 1'b1;
    tick(10);
  endtask

  // Clocks nclk bits of a bits-long word, MSB first, and collects miso.
  task automatic shift_bits(input int bits, input int nclk, input logic [15:0] mo,
                            output logic [15:0] mi);
    mi = '0;
    for (int k = 0; k < nclk; k++) begin
      int i;
      i = bits - 1 - k;
      if (!cfg_cpha) begin
        mosi = mo[i];
        tick(HALF);
        mi = {mi[14:0], miso};
        sclk = ~cfg_cpol;
        tick(HALF);
        sclk = cfg_cpol;
      end else begin
        sclk = ~cfg_cpol;
        mosi = mo[i];
        tick(HALF);
        mi = {mi[14:0], miso};
        sclk = cfg_cpol;
        tick(HALF);
      end
    end
  endtask

  task automatic xfer(input int bits, input logic [15:0] mo, input logic [15:0] exp_mi,
                      input bit store, input string req);
    logic [15:0] mi;
    if (store) exp_q.push_back(mo & fmask(bits));
    cs_low();
    shift_bits(bits, bits, mo, mi);
    cs_high();
    check(mi == (exp_mi & fmask(bits)), req, "miso word", {16'h0, mi},
          {16'h0, exp_mi & fmask(bits)});
  endtask

  task automatic drain_wait();
    for (int t = 0; t < 200 && exp_q.size() != 0; t++) tick(1);
    tick(4);
    check(exp_q.size() == 0, "R2", "scoreboard drained", exp_q.size(), 0);
  endtask

  task automatic clear_flags();
    @(negedge clk);
    flag_clr = 2'b11;
    @(negedge clk);
    flag_clr = 2'b00;
    tick(1);
  endtask

  initial begin
    tick(5);
    // R1: reset values
    check(miso == 1'b1, "R1", "miso idle", miso, 1);
    check(!flag_udf && !flag_ovf && !irq, "R1", "flags and irq",
          {flag_ovf, flag_udf, irq}, 0);
    check(!rx_rvalid && !tx_full, "R1", "fifo status", {rx_rvalid, tx_full}, 0);
    rst_n = 1'b1;
    tick(4);

    // R3: all four polarity/phase pairs, 8 bits
    for (int m = 0; m < 4; m++) begin
      set_cfg(m[1], m[0], 5'd8);
      push_tx(16'h00A5 ^ 16'(m));
      xfer(8, 16'h003C + 16'(m * 7), 16'h00A5 ^ 16'(m), 1'b1, "R3");
    end
    drain_wait();

    // R2: 4-bit and 16-bit frames, and clamped length settings
    set_cfg(1'b0, 1'b1, 5'd16);
    push_tx(16'hC3E1);
    xfer(16, 16'h8F12, 16'hC3E1, 1'b1, "R2");
    set_cfg(1'b1, 1'b0, 5'd4);
    push_tx(16'h0009);
    xfer(4, 16'h0006, 16'h0009, 1'b1, "R2");
    set_cfg(1'b0, 1'b0, 5'd2);
    push_tx(16'h000B);
    xfer(4, 16'h0005, 16'h000B, 1'b1, "R2 clamp low");
    set_cfg(1'b0, 1'b0, 5'd31);
    push_tx(16'h7E81);
    xfer(16, 16'h1234, 16'h7E81, 1'b1, "R2 clamp high");
    drain_wait();
    check(!flag_udf && !flag_ovf, "R2", "no error flags", {flag_ovf, flag_udf}, 0);

    // R4: phase 1, two frames under one select
    set_cfg(1'b0, 1'b1, 5'd8);
    push_tx(16'h0011);
    push_tx(16'h00EE);
    begin
      logic [15:0] mi;
      exp_q.push_back(16'h0055);
      exp_q.push_back(16'h00AA);
      cs_low();
      shift_bits(8, 8, 16'h0055, mi);
      check(mi == 16'h0011, "R4", "first back-to-back word", mi, 16'h0011);
      shift_bits(8, 8, 16'h00AA, mi);
      check(mi == 16'h00EE, "R4", "second back-to-back word", mi, 16'h00EE);
      cs_high();
    end
    drain_wait();

    // R5 / R10 / R9: underflow, masking, clearing
    set_cfg(1'b0, 1'b0, 5'd8);
    irq_mask = 2'b01;
    xfer(8, 16'h0042, 16'hFFFF, 1'b1, "R5");
    drain_wait();
    check(flag_udf == 1'b1, "R5", "underflow flag", flag_udf, 1);
    check(irq == 1'b0, "R10", "masked underflow irq", irq, 0);
    irq_mask = 2'b00;
    tick(1);
    check(irq == 1'b1, "R10", "unmasked underflow irq", irq, 1);
    @(negedge clk);
    flag_clr = 2'b10;
    @(negedge clk);
    flag_clr = 2'b00;
    check(flag_udf == 1'b1, "R9", "udf kept by other clear bit", flag_udf, 1);
    @(negedge clk);
    flag_clr = 2'b01;
    @(negedge clk);
    flag_clr = 2'b00;
    check(flag_udf == 1'b0 && irq == 1'b0, "R9", "udf cleared", {flag_udf, irq}, 0);

    // R6: overflow after RX_DEPTH stored frames
    mon_en = 1'b0;
    for (int f = 0; f < 5; f++) begin
      push_tx(16'h0030 + 16'(f));
      xfer(8, 16'h0090 + 16'(f), 16'h0030 + 16'(f), f < 4, "R6");
    end
    check(flag_ovf == 1'b1, "R6", "overflow flag", flag_ovf, 1);
    check(flag_udf == 1'b0, "R6", "no underflow during fill", flag_udf, 0);
    irq_mask = 2'b10;
    tick(1);
    check(irq == 1'b0, "R10", "masked overflow irq", irq, 0);
    irq_mask = 2'b00;
    mon_en = 1'b1;
    drain_wait();
    clear_flags();
    check(!flag_ovf, "R9", "ovf cleared", flag_ovf, 0);

    // R7: select released after three bits
    push_tx(16'h0081);
    begin
      logic [15:0] mi;
      cs_low();
      shift_bits(8, 3, 16'h00FF, mi);
      cs_high();
    end
    tick(4);
    check(rx_rvalid == 1'b0, "R7", "partial frame not stored", rx_rvalid, 0);
    push_tx(16'h0042);
    xfer(8, 16'h005A, 16'h0042, 1'b1, "R7 next frame");
    drain_wait();

    // R8: send-only mode
    cfg_mode = 2'b01;
    push_tx(16'h0077);
    xfer(8, 16'h00C8, 16'h0077, 1'b0, "R8 send only");
    tick(4);
    check(rx_rvalid == 1'b0, "R8", "send-only stores nothing", rx_rvalid, 0);
    // R8: receive-only mode keeps the queued word for later
    cfg_mode = 2'b10;
    push_tx(16'h0066);
    xfer(8, 16'h0019, 16'hFFFF, 1'b1, "R8 receive only");
    drain_wait();
    check(flag_udf == 1'b0, "R8", "receive-only no underflow", flag_udf, 0);
    cfg_mode = 2'b00;
    xfer(8, 16'h0024, 16'h0066, 1'b1, "R8 word kept");
    drain_wait();

    // R11: transmit FIFO fill and ignored write
    for (int w = 0; w < 5; w++) push_tx(16'h0050 + 16'(w));
    check(tx_full == 1'b1, "R11", "tx full", tx_full, 1);
    for (int w = 0; w < 4; w++)
      xfer(8, 16'h0010 + 16'(w), 16'h0050 + 16'(w), 1'b1, "R11");
    check(flag_udf == 1'b0, "R11", "no underflow yet", flag_udf, 0);
    xfer(8, 16'h0020, 16'hFFFF, 1'b1, "R11 extra write dropped");
    check(flag_udf == 1'b1, "R5", "underflow after drop", flag_udf, 1);
    drain_wait();
    clear_flags();

    report();
  end
endmodule